// File: doc/BRIEF.md
# Configuration DMA command queue

This block is the command front end of a DMA engine that streams a configuration image from memory into a configuration port. Software fills four staging registers over a simple register write bus: source address, destination address, source length and destination length. The write to the destination-length register commits the staged values as one command into a small in-order queue. Commands with a zero length or a misaligned address are rejected, and commits into a full queue are dropped with an overflow event.

An engine takes commands from the queue one at a time and presents them on a word-stream request interface as a word address and a remaining word count. Each acknowledge consumes one word. When the last word of a command is acknowledged, the block raises a DMA-done event. A command whose source address has bit 0 set is the final segment of an image. After such a command the engine waits until the configuration port reports that it is idle, then raises a port-done event, and only then takes the next command. Queue full and empty flags appear in a status word.

Top module: `cfg_dma_cmdq`

## Requirements
- R1: After reset the queue is empty (status bit 30 = 1, bit 31 = 0), no request is presented and the event vector is zero.
- R2: Register offsets are 0x18 source address, 0x1C destination address, 0x20 source length and 0x24 destination length. A write to 0x24 commits the most recently written source address and source length as one command. Writes to any other offset have no effect.
- R3: The source length is taken from bits 26:0 of the written word and counts 32-bit words. reqCount starts at that value, and each cycle with reqValid and reqAck high advances reqAddr by 4 and lowers reqCount by 1.
- R4: The request starts at the source address with bits 1:0 cleared. Bit 0 of the source address marks the command as final.
- R5: A commit whose staged length is zero or whose staged address has bit 1 set drops the command and raises eventVec bit 15 for one cycle, in the cycle after the commit.
- R6: A valid commit while the queue already holds DEPTH commands drops the command and raises eventVec bit 14 for one cycle, in the cycle after the commit.
- R7: statusWord bit 31 is 1 exactly when the queue holds DEPTH commands. Bit 30 is 1 exactly when it holds none. All other status bits are 0.
- R8: Commands are issued strictly in commit order. The next command is taken in the first cycle the engine is idle and the queue is not empty.
- R9: Acknowledging the last word of any command raises eventVec bit 13 for one cycle, in the following cycle.
- R10: After the last word of a final command, the engine waits for cfgPortIdle to be high. It then raises eventVec bit 12 for one cycle, in the following cycle, and takes no new command before that.
- R11: Values written to the destination address and destination length registers have no effect on the requests or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Register write data |
| statusWord | output | 32 | Bit 31 queue full, bit 30 queue empty |
| reqValid | output | 1 | A word request is presented |
| reqAddr | output | 32 | Byte address of the current word |
| reqCount | output | 27 | Words remaining in the current command |
| reqAck | input | 1 | One word accepted |
| cfgPortIdle | input | 1 | Configuration port has drained |
| eventVec | output | 16 | One-cycle events: 12 port-done, 13 DMA-done, 14 overflow, 15 command error |

## Verification
The bench compares the block against a behavioural queue model on every clock. Four kinds of traffic are used. Single commands with a permanent acknowledge check the address and count stepping. Final commands with a late port-idle show whether port-done waits for the drain and blocks the next command. Commits with a zero length, address bit 1 set, or oversized length words show that rejection and masking are separate from the overflow path. A back-pressured burst that overfills the queue, followed by irregular acknowledges and junk destination and off-map writes, shows the full and empty flags, the overflow drop and strict ordering.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  localparam int LEN_W = 27;

  localparam logic [7:0] OFF_SRC_ADDR = 8'h18;
  localparam logic [7:0] OFF_DST_ADDR = 8'h1C;
  localparam logic [7:0] OFF_SRC_LEN  = 8'h20;
  localparam logic [7:0] OFF_DST_LEN  = 8'h24;

  typedef struct packed {
    logic [29:0]      wordAddr;
    logic [LEN_W-1:0] words;
    logic             isFinal;
  } cmd_t;

  typedef struct packed {
    logic load;
    logic step;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } eng_state_t;
endpackage

// File: rtl/cdq_data.sv
module cdq_data
  import cdq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]      regWrData,
  input  strobe_t          stb,
  output logic             qEmpty,
  output logic             qFull,
  output logic [31:0]      curByteAddr,
  output logic [LEN_W-1:0] curCount,
  output logic             curFinal,
  output logic             lastWord,
  output logic             errStb,
  output logic             ovfStb
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [31:0]      stgSrc;
  logic [LEN_W-1:0] stgLen;
  cmd_t             slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fill;
  logic [29:0]      curWord;

  logic commitHit, badCmd, doPush;

  assign commitHit = regWrEn && (regAddr == ADDR_W'(OFF_DST_LEN));
  assign badCmd    = (stgLen == '0) || stgSrc[1];
  assign qFull     = (fill == CNT_FULL);
  assign qEmpty    = (fill == '0);
  assign errStb    = commitHit && badCmd;
  assign ovfStb    = commitHit && !badCmd && qFull;
  assign doPush    = commitHit && !badCmd && !qFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgSrc <= '0;
      stgLen <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(OFF_SRC_ADDR)) stgSrc <= regWrData;
      if (regAddr == ADDR_W'(OFF_SRC_LEN))  stgLen <= regWrData[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= '{wordAddr: stgSrc[31:2], words: stgLen, isFinal: stgSrc[0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush)   wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (stb.load) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !stb.load)      fill <= fill + 1'b1;
      else if (!doPush && stb.load) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWord  <= '0;
      curCount <= '0;
      curFinal <= 1'b0;
    end else if (stb.load) begin
      curWord  <= slots[rdPtr].wordAddr;
      curCount <= slots[rdPtr].words;
      curFinal <= slots[rdPtr].isFinal;
    end else if (stb.step) begin
      curWord  <= curWord + 1'b1;
      curCount <= curCount - 1'b1;
    end
  end

  assign curByteAddr = {curWord, 2'b00};
  assign lastWord    = (curCount == LEN_W'(1));
endmodule

// File: rtl/cdq_ctrl.sv
module cdq_ctrl
  import cdq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    qEmpty,
  input  logic    reqAck,
  input  logic    lastWord,
  input  logic    curFinal,
  input  logic    cfgPortIdle,
  output strobe_t stb,
  output logic    reqValid,
  output logic    dmaDoneStb,
  output logic    portDoneStb
);
  eng_state_t state, nextState;

  always_comb begin
    nextState   = state;
    stb         = '0;
    dmaDoneStb  = 1'b0;
    portDoneStb = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!qEmpty) begin
          stb.load  = 1'b1;
          nextState = ST_RUN;
        end
      end
      ST_RUN: begin
        stb.step = reqAck;
        if (reqAck && lastWord) begin
          dmaDoneStb = 1'b1;
          nextState  = curFinal ? ST_DRAIN : ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (cfgPortIdle) begin
          portDoneStb = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqValid = (state == ST_RUN);
endmodule

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq
  import cdq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       statusWord,
  output logic              reqValid,
  output logic [31:0]       reqAddr,
  output logic [LEN_W-1:0]  reqCount,
  input  logic              reqAck,
  input  logic              cfgPortIdle,
  output logic [15:0]       eventVec
);
  strobe_t stb;
  logic qEmpty, qFull, curFinal, lastWord;
  logic errStb, ovfStb, dmaDoneStb, portDoneStb;

  cdq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .stb(stb), .qEmpty(qEmpty), .qFull(qFull),
    .curByteAddr(reqAddr), .curCount(reqCount), .curFinal(curFinal),
    .lastWord(lastWord), .errStb(errStb), .ovfStb(ovfStb)
  );

  cdq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .qEmpty(qEmpty), .reqAck(reqAck),
    .lastWord(lastWord), .curFinal(curFinal), .cfgPortIdle(cfgPortIdle),
    .stb(stb), .reqValid(reqValid), .dmaDoneStb(dmaDoneStb),
    .portDoneStb(portDoneStb)
  );

  always_ff @(posedge clk) begin
    if (!rstN) eventVec <= '0;
    else       eventVec <= {errStb, ovfStb, dmaDoneStb, portDoneStb, 12'b0};
  end

  assign statusWord = {qFull, qEmpty, 30'b0};
endmodule

// File: rtl/cfg_dma_cmdq_chk.sv
module cfg_dma_cmdq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       statusWord,
  input logic              reqValid,
  input logic [31:0]       reqAddr,
  input logic [26:0]       reqCount,
  input logic              reqAck,
  input logic              cfgPortIdle,
  input logic [15:0]       eventVec
);
  // R7
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWord[31] && statusWord[30]));

  // R3
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck) |=> (reqValid && $stable(reqAddr) && $stable(reqCount)));

  // R9
  dma_done_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventVec[13] |-> $past(reqValid && reqAck));

  // R5
  cmd_err_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventVec[15] |-> $past(regWrEn && regAddr == ADDR_W'(8'h24)));

  // R6
  overflow_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventVec[14] |-> $past(statusWord[31]));

  // R10
  port_done_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventVec[12] |-> ($past(cfgPortIdle) && !$past(reqValid)));

  // R3
  no_zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqCount != 27'd0));
endmodule

bind cfg_dma_cmdq cfg_dma_cmdq_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .statusWord(statusWord), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqCount(reqCount), .reqAck(reqAck), .cfgPortIdle(cfgPortIdle),
  .eventVec(eventVec)
);

// File: tb/sim_cfg_dma_cmdq.sv
`timescale 1ns/1ps
module sim_cfg_dma_cmdq;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] statusWord;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic [26:0] reqCount;
  logic        reqAck = 1'b0;
  logic        cfgPortIdle = 1'b0;
  logic [15:0] eventVec;

  int checks = 0;
  int fails = 0;
  int ackMode = 0;   // 0 always, 1 never, 2 irregular
  int idleMode = 0;  // 0 always, 1 never, 2 irregular

  always #2 clk = ~clk;

  cfg_dma_cmdq #(.DEPTH(DEPTH), .ADDR_W(8)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .statusWord(statusWord), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqCount(reqCount), .reqAck(reqAck),
    .cfgPortIdle(cfgPortIdle), .eventVec(eventVec)
  );

  // Behavioural reference model
  typedef struct {
    int unsigned addr;
    int unsigned len;
    bit          fin;
  } mcmd_t;
  mcmd_t       mq[$];
  mcmd_t       mc;
  int          mSt = 0;
  int unsigned mAddr = 0, mCnt = 0;
  bit          mFin = 0;
  bit [31:0]   sSrc = 0;
  int unsigned sLen = 0;
  bit [15:0]   mEvt = 0, evtN;
  bit          wasFull;

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete();
      mSt = 0; mAddr = 0; mCnt = 0; mFin = 0; sSrc = 0; sLen = 0; mEvt = 0;
    end else begin
      evtN = 0;
      wasFull = (mq.size() == DEPTH);
      case (mSt)
        0: if (mq.size() > 0) begin
             mc = mq.pop_front();
             mAddr = mc.addr; mCnt = mc.len; mFin = mc.fin; mSt = 1;
           end
        1: if (reqAck) begin
             if (mCnt == 1) begin
               evtN[13] = 1'b1;
               mSt = mFin ? 2 : 0;
             end else begin
               mAddr += 4; mCnt -= 1;
             end
           end
        default: if (cfgPortIdle) begin
             evtN[12] = 1'b1; mSt = 0;
           end
      endcase
      if (regWrEn) begin
        if (regAddr == 8'h18) sSrc = regWrData;
        else if (regAddr == 8'h20) sLen = regWrData & 32'h07FF_FFFF;
        else if (regAddr == 8'h24) begin
          if (sLen == 0 || sSrc[1]) evtN[15] = 1'b1;
          else if (wasFull) evtN[14] = 1'b1;
          else mq.push_back('{addr: sSrc & 32'hFFFF_FFFC, len: sLen, fin: sSrc[0]});
        end
      end
      mEvt = evtN;
    end
  end

  // Stimulus for acknowledge and port idle, driven away from the active edge
  always @(negedge clk) begin
    reqAck      <= (ackMode == 0) ? 1'b1 : (ackMode == 1) ? 1'b0 : 1'($urandom_range(0, 1));
    cfgPortIdle <= (idleMode == 0) ? 1'b1 : (idleMode == 1) ? 1'b0 : ($urandom_range(0, 3) == 0);
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (statusWord != {mq.size() == DEPTH, mq.size() == 0, 30'b0}) begin
        fails++;
        $display("FAIL R7 status actual=%h expected full=%0d empty=%0d", statusWord,
                 mq.size() == DEPTH, mq.size() == 0);
      end
      checks++;
      if (reqValid !== (mSt == 1) ||
          (mSt == 1 && (reqAddr !== mAddr || reqCount !== 27'(mCnt)))) begin
        fails++;
        $display("FAIL R2 R3 R4 R8 R11 req actual=%0b/%h/%0d expected=%0b/%h/%0d",
                 reqValid, reqAddr, reqCount, mSt == 1, mAddr, mCnt);
      end
      checks++;
      if (eventVec !== mEvt) begin
        fails++;
        $display("FAIL R5 R6 R9 R10 events actual=%h expected=%h", eventVec, mEvt);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic cmd(input logic [31:0] src, input logic [31:0] len);
    wr(8'h18, src);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, len);
    wr(8'h24, 32'h0);
  endtask

  task automatic settle();
    int guard = 0;
    while ((mSt != 0 || mq.size() != 0) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (statusWord !== 32'h4000_0000 || reqValid !== 1'b0 || eventVec !== 16'h0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%0b/%h expected=40000000/0/0000",
               statusWord, reqValid, eventVec);
    end

    // R3 R4 R9 single plain command
    cmd(32'h0000_1000, 32'd3);
    settle();
    // R4 R10 final command with a late drain
    idleMode = 1;
    cmd(32'h0000_2001, 32'd2);
    cmd(32'h0000_3000, 32'd1);
    repeat (30) @(negedge clk);
    idleMode = 0;
    settle();
    // R5 zero length and address bit 1
    cmd(32'h0000_4000, 32'd0);
    cmd(32'h0000_4002, 32'd2);
    // R3 length masked to 27 bits
    cmd(32'h0000_5000, 32'hF800_0002);
    settle();
    // R6 R7 R8 overfill with back-pressure
    ackMode = 1;
    for (int i = 0; i < 7; i++) cmd(32'h0001_0000 + 32'(i * 256), 32'(i + 1));
    repeat (5) @(negedge clk);
    ackMode = 0;
    settle();
    // R8 R10 R11 irregular handshakes, junk destination and off-map writes
    ackMode = 2; idleMode = 2;
    for (int i = 0; i < 12; i++) begin
      wr(8'h18, 32'h0002_0000 + 32'(i * 64) + 32'(i % 3 == 0));
      wr(8'h1C, $urandom);
      wr(8'h28, $urandom);
      wr(8'h20, 32'(1 + i % 5));
      wr(8'h24, $urandom);
    end
    settle();
    ackMode = 0; idleMode = 0;
    settle();

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule